// File: doc/BRIEF.md
# Dual-Mode Memory Address Pointer

This block holds the byte address for a 2048-byte serial memory. The address is 11 bits wide. Its three top bits come from the block-select field of the bus select byte, and its low eight bits come from the word-address byte. A bus controller sends separate load strobes for the two fields, each with its value. It sends an increment strobe after every data byte, together with a mode bit that says whether the transfer is a write or a read.

The mode bit decides how the pointer steps. In a write, the pointer wraps inside an aligned 32-byte page, so the page number never changes. In a read, the pointer counts through the whole 2048-byte space and rolls over from the last byte to the first. The pointer keeps its value between transactions, so a later read that sends only a select byte carries on from the retained offset. The memory array and the bus timing are handled by other blocks.

Top module: `addr_ptr`

## Requirements
- R1: When the active-low reset is asserted, `addr_o` becomes 0 and stays 0 for as long as reset is held.
- R2: A `blk_ld_i` pulse copies `blk_i` into address bits 10:8 on the next clock edge. Bits 7:0 keep their value unless `word_ld_i` is also high.
- R3: A `word_ld_i` pulse copies `word_i` into address bits 7:0 on the next clock edge. Bits 10:8 keep their value unless `blk_ld_i` is also high.
- R4: A `step_i` pulse with `rd_mode_i` = 0 (write) adds one to bits 4:0 modulo 32 and leaves bits 10:5 unchanged. For example, 0x01F goes to 0x000 and 0x03F goes to 0x020.
- R5: A `step_i` pulse with `rd_mode_i` = 1 (read) adds one to the full 11-bit address modulo 2048. The carry crosses page and block boundaries (0x5FF goes to 0x600), and 0x7FF goes to 0x000.
- R6: In a cycle with no load strobe and no step strobe, the address holds its value whatever the state of `rd_mode_i`.
- R7: When any load strobe is high, `step_i` is ignored in that cycle. The result is the loaded value with no increment applied.
- R8: When both load strobes are high in the same cycle, the whole 11-bit address is replaced by {`blk_i`, `word_i`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all updates happen on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| blk_ld_i | input | 1 | Strobe that loads the block-select field |
| blk_i | input | 3 | Block-select value, goes into address bits 10:8 |
| word_ld_i | input | 1 | Strobe that loads the word-address field |
| word_i | input | 8 | Word-address value, goes into address bits 7:0 |
| step_i | input | 1 | Advance the pointer by one byte |
| rd_mode_i | input | 1 | 1 = read (full roll-over), 0 = write (page wrap) |
| addr_o | output | 11 | Current byte address (registered) |

## Verification
Every state bit of this block is visible on `addr_o`, one clock edge after the strobe that changed it. A fault in the page wrap only shows when a write step starts from an offset of 31 inside a page. It then appears as a carry into bit 5 in the very next cycle. A fault in the full roll-over, or in how a field load keeps the other field, shows only at block boundaries (0x?FF, 0x7FF) and on a select-byte-only load. The bench places stimulus at exactly those points and checks the output one cycle after each strobe.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

   // Direction of the transfer that owns the current increment.
   typedef enum logic {
      MODE_WRITE = 1'b0,
      MODE_READ  = 1'b1
   } step_mode_e;

   // Default geometry of the pointer.
   localparam int unsigned DEF_BLK_W  = 3;
   localparam int unsigned DEF_WORD_W = 8;
   localparam int unsigned DEF_PAGE_W = 5;

endpackage

// File: rtl/addr_ptr_incr.sv
module addr_ptr_incr #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned PAGE_W = 5
) (
   input  logic [ADDR_W-1:0]        cur_i,
   input  addr_ptr_pkg::step_mode_e mode_i,
   output logic [ADDR_W-1:0]        nxt_o
);

   import addr_ptr_pkg::*;

   // Linear successor: used by reads, rolls over at the top of the space.
   logic [ADDR_W-1:0] lin_nxt;
   assign lin_nxt = cur_i + ADDR_W'(1);

   generate
      if (PAGE_W == 0) begin : g_bad_page
         $error("addr_ptr_incr: PAGE_W must be at least 1");
      end
      if (PAGE_W < ADDR_W) begin : g_paged
         // Write increment touches only the in-page offset.
         logic [PAGE_W-1:0] off_nxt;
         assign off_nxt = cur_i[PAGE_W-1:0] + PAGE_W'(1);
         always_comb begin
            if (mode_i == MODE_READ) nxt_o = lin_nxt;
            else                     nxt_o = {cur_i[ADDR_W-1:PAGE_W], off_nxt};
         end
      end else begin : g_flat
         // A page covering the whole space: both modes behave alike.
         logic unused_mode;
         assign unused_mode = mode_i;
         assign nxt_o = lin_nxt;
      end
   endgenerate

endmodule

// File: rtl/addr_ptr_load.sv
module addr_ptr_load #(
   parameter int unsigned BLK_W  = 3,
   parameter int unsigned WORD_W = 8,
   localparam int unsigned ADDR_W = BLK_W + WORD_W
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic              blk_ld_i,
   input  logic [BLK_W-1:0]  blk_i,
   input  logic              word_ld_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [ADDR_W-1:0] merged_o,
   output logic              any_ld_o
);

   logic [BLK_W-1:0]  hi_sel;
   logic [WORD_W-1:0] lo_sel;

   // Each field is replaced on its own strobe, otherwise kept.
   always_comb begin
      hi_sel = blk_ld_i  ? blk_i  : cur_i[ADDR_W-1:WORD_W];
      lo_sel = word_ld_i ? word_i : cur_i[WORD_W-1:0];
   end

   assign merged_o = {hi_sel, lo_sel};
   assign any_ld_o = blk_ld_i | word_ld_i;

endmodule

// File: rtl/addr_ptr.sv
module addr_ptr #(
   parameter int unsigned BLK_W  = addr_ptr_pkg::DEF_BLK_W,
   parameter int unsigned WORD_W = addr_ptr_pkg::DEF_WORD_W,
   parameter int unsigned PAGE_W = addr_ptr_pkg::DEF_PAGE_W,
   localparam int unsigned ADDR_W = BLK_W + WORD_W
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              blk_ld_i,
   input  logic [BLK_W-1:0]  blk_i,
   input  logic              word_ld_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              step_i,
   input  logic              rd_mode_i,
   output logic [ADDR_W-1:0] addr_o
);

   import addr_ptr_pkg::*;

   generate
      if (BLK_W == 0 || WORD_W == 0) begin : g_bad_fields
         $error("addr_ptr: field widths must be non-zero");
      end
      if (PAGE_W > WORD_W) begin : g_bad_page
         $error("addr_ptr: a page may not span more than one word field");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_d;
   logic [ADDR_W-1:0] load_val;
   logic [ADDR_W-1:0] step_val;
   logic              any_ld;
   step_mode_e        mode;

   assign mode = step_mode_e'(rd_mode_i);

   addr_ptr_load #(
      .BLK_W  (BLK_W),
      .WORD_W (WORD_W)
   ) i_load (
      .cur_i     (ptr_q),
      .blk_ld_i  (blk_ld_i),
      .blk_i     (blk_i),
      .word_ld_i (word_ld_i),
      .word_i    (word_i),
      .merged_o  (load_val),
      .any_ld_o  (any_ld)
   );

   addr_ptr_incr #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) i_incr (
      .cur_i  (ptr_q),
      .mode_i (mode),
      .nxt_o  (step_val)
   );

   // Loads win over increments; with no strobe the pointer holds.
   always_comb begin
      if (any_ld)      ptr_d = load_val;
      else if (step_i) ptr_d = step_val;
      else             ptr_d = ptr_q;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) ptr_q <= '0;
      else          ptr_q <= ptr_d;
   end

   assign addr_o = ptr_q;

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         a_r1_reset_zero : assert (addr_o == '0)
            else $error("R1: pointer not zero during reset");
      end
   end

   a_r2_blk_load : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      blk_ld_i |=> addr_o[ADDR_W-1:WORD_W] == $past(blk_i));

   a_r3_word_load : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      word_ld_i |=> addr_o[WORD_W-1:0] == $past(word_i));

   a_r3_word_keeps_blk : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (word_ld_i && !blk_ld_i) |=> $stable(addr_o[ADDR_W-1:WORD_W]));

   a_r4_page_fixed : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (step_i && !blk_ld_i && !word_ld_i && !rd_mode_i)
         |=> $stable(addr_o[ADDR_W-1:PAGE_W]));

   a_r4_page_wrap : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (step_i && !blk_ld_i && !word_ld_i && !rd_mode_i && (&addr_o[PAGE_W-1:0]))
         |=> addr_o[PAGE_W-1:0] == '0);

   a_r5_read_roll : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (step_i && !blk_ld_i && !word_ld_i && rd_mode_i && (&addr_o))
         |=> addr_o == '0);

   a_r6_hold : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!step_i && !blk_ld_i && !word_ld_i) |=> $stable(addr_o));

   a_r8_full_load : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (blk_ld_i && word_ld_i) |=> addr_o == {$past(blk_i), $past(word_i)});

endmodule

// File: tb/test_addr_ptr.sv
module test_addr_ptr;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_ld = 1'b0;
   logic [2:0]  blk = '0;
   logic        word_ld = 1'b0;
   logic [7:0]  word = '0;
   logic        step = 1'b0;
   logic        rd_mode = 1'b0;
   logic [10:0] addr;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_ptr i_addr_ptr (
      .clk_i     (clk),
      .rst_n_i   (rst_n),
      .blk_ld_i  (blk_ld),
      .blk_i     (blk),
      .word_ld_i (word_ld),
      .word_i    (word),
      .step_i    (step),
      .rd_mode_i (rd_mode),
      .addr_o    (addr)
   );

   // Vector: {blk_ld, blk[3], word_ld, word[8], step, rd, expected[11], req[4]}
   localparam logic [29:0] VEC [NVEC] = '{
      {1'b0, 3'd0, 1'b1, 8'h1E, 1'b0, 1'b0, 11'h01E, 4'd3}, // R3 word load
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h01F, 4'd4}, // R4 write step
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h000, 4'd4}, // R4 31 -> 0
      {1'b1, 3'd5, 1'b0, 8'h00, 1'b0, 1'b0, 11'h500, 4'd2}, // R2 block load
      {1'b0, 3'd0, 1'b1, 8'h3F, 1'b0, 1'b0, 11'h53F, 4'd3}, // R3 keeps block
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h520, 4'd4}, // R4 63 -> 32
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h521, 4'd5}, // R5 read step
      {1'b0, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b1, 11'h5FF, 4'd3}, // R3
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h600, 4'd5}, // R5 block carry
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 11'h600, 4'd6}, // R6 idle
      {1'b1, 3'd7, 1'b1, 8'hFF, 1'b1, 1'b1, 11'h7FF, 4'd8}, // R8 + R7
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 11'h000, 4'd5}, // R5 2047 -> 0
      {1'b1, 3'd2, 1'b0, 8'h00, 1'b1, 1'b0, 11'h200, 4'd7}, // R7 step ignored
      {1'b0, 3'd0, 1'b1, 8'hDF, 1'b0, 1'b0, 11'h2DF, 4'd3}, // R3
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 11'h2C0, 4'd4}, // R4 wrap in page 6
      {1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 11'h2C0, 4'd6}, // R6 idle write
      {1'b1, 3'd3, 1'b0, 8'h00, 1'b0, 1'b1, 11'h3C0, 4'd2}  // R2 keeps offset
   };

   task automatic check(input logic [10:0] exp, input int req, input string what);
      n_run++;
      if (addr !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual 0x%03h expected 0x%03h", req, what, addr, exp);
      end
   endtask

   task automatic idle_inputs();
      blk_ld = 1'b0; word_ld = 1'b0; step = 1'b0; rd_mode = 1'b0;
      blk = '0; word = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, held over several edges
      idle_inputs();
      word_ld = 1'b1; word = 8'hAA; step = 1'b1;
      repeat (3) @(negedge clk);
      check(11'h000, 1, "reset state");
      idle_inputs();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(11'h000, 1, "after reset release");

      // Vector walk: drive on the falling edge, check one rising edge later
      for (int k = 0; k < NVEC; k++) begin
         {blk_ld, blk, word_ld, word, step, rd_mode} = VEC[k][29:15];
         @(negedge clk);
         check(VEC[k][14:4], int'(VEC[k][3:0]), $sformatf("vector %0d", k));
         idle_inputs();
      end

      // R6: hold over several idle cycles in read mode
      rd_mode = 1'b1;
      repeat (4) @(negedge clk);
      check(11'h3C0, 6, "long idle read mode");

      // R4: a full page of write steps comes back to the start
      word_ld = 1'b1; word = 8'h45; blk_ld = 1'b1; blk = 3'd1;
      @(negedge clk);
      idle_inputs();
      step = 1'b1;
      repeat (32) @(negedge clk);
      check(11'h145, 4, "32 write steps return to start");

      // R5: 0x1FF read step goes into block 2
      idle_inputs();
      word_ld = 1'b1; word = 8'hFF;
      @(negedge clk);
      idle_inputs();
      step = 1'b1; rd_mode = 1'b1;
      @(negedge clk);
      check(11'h200, 5, "read crosses block");

      // R7: word load with step in write mode
      idle_inputs();
      word_ld = 1'b1; word = 8'h1F; step = 1'b1;
      @(negedge clk);
      check(11'h21F, 7, "load wins over step");

      // R1: reset in the middle of operation
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      check(11'h000, 1, "mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule